// File: doc/BRIEF.md
# Two-Stage SAR Digital Back End with Four-Sample Averager

This block sits behind a two-stage successive-approximation converter. Each conversion delivers a 4-bit coarse decision and a 5-bit fine decision. The coarse stage carries one redundant bit, so its last step overlaps the range of the fine stage by one bit. The block removes that overlap digitally. It weights the coarse code by sixteen, adds the fine code and subtracts a fixed offset of eight. The result is clamped into an 8-bit word.

Each corrected word is presented on a registered output. The word also goes into a 10-bit accumulator that sums four consecutive valid words. When the fourth word of a frame arrives, the block captures the frame total and pulses a report strobe for one cycle. The total is read as an average in 8.2 fixed point: the upper eight bits are the integer part and the lower two bits are the fraction. The next frame starts from the next valid word, so no word is dropped at a frame boundary.

Top module: `sar_be_top`

## Requirements
- R1: When coarse*16 + fine lies between 8 and 263, the corrected word equals coarse*16 + fine - 8.
- R2: When coarse*16 + fine is below 8, the corrected word is 0.
- R3: When coarse*16 + fine is above 263, the corrected word is 255.
- R4: The corrected word and a high `sample_vld_o` appear in the cycle after the clock edge that samples `word_vld` high. `sample_vld_o` is low after an edge with `word_vld` low, and `sample_o` then keeps its value.
- R5: Every fourth valid word, `avg_o` takes the 10-bit sum of the four corrected words of that frame, read as integer bits [9:2] and fraction bits [1:0].
- R6: `avg_vld_o` is high for exactly one cycle, the same cycle in which the fourth valid word of a frame is reported. Cycles with `word_vld` low do not advance the frame.
- R7: A new frame begins with the valid word that follows a report. No earlier sum carries into it, and no word is skipped.
- R8: A synchronous reset `rst` (active high) clears `sample_o`, `sample_vld_o`, `avg_o`, `avg_vld_o` and the frame position. Words already summed in a partial frame are discarded.
- R9: Between reports, `avg_o` holds the last reported value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| word_vld | input | 1 | Coarse and fine codes are valid this cycle |
| coarse_code | input | 4 | First-stage decision, one redundant bit |
| fine_code | input | 5 | Second-stage decision |
| sample_o | output | 8 | Corrected conversion word |
| sample_vld_o | output | 1 | `sample_o` updated this cycle |
| avg_o | output | 10 | Four-word sum, 8.2 fixed-point average |
| avg_vld_o | output | 1 | `avg_o` updated this cycle |

## Verification
The fourth valid word of a frame updates the single-word output and the frame report on the same edge. The bench drives frames whose closing word is an extreme code, such as coarse 15 with fine 31 or coarse 0 with fine 0. It then checks that the clamped word appears both on `sample_o` and inside `avg_o` in that cycle. A reset is also applied in the cycle in which a word is valid and a frame would otherwise close. Reset must win in that case, and the next frame must count from one again. Every output is compared with a behavioural queue model on every clock.

// File: rtl/sar_be_pkg.sv
package sar_be_pkg;

    parameter int COARSE_W  = 4;
    parameter int FINE_W    = 5;
    parameter int SAMPLE_W  = 8;
    parameter int FRAME_LEN = 4;

    localparam int CNT_W    = $clog2(FRAME_LEN);
    localparam int AVG_W    = SAMPLE_W + CNT_W;

    typedef struct packed {
        logic [AVG_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
        logic [AVG_W-1:0] avg;
        logic             avg_vld;
    } avg_state_t;

    typedef struct packed {
        logic [SAMPLE_W-1:0] sample;
        logic                vld;
    } out_state_t;

endpackage

// File: rtl/sar_be_combine.sv
module sar_be_combine
    import sar_be_pkg::*;
#(
    parameter int CW = COARSE_W,
    parameter int FW = FINE_W,
    parameter int OW = SAMPLE_W
) (
    input  logic [CW-1:0] coarse,
    input  logic [FW-1:0] fine,
    output logic [OW-1:0] word
);
    // Coarse step is half the fine span: one bit of overlap.
    localparam int SHIFT = FW - 1;
    localparam int SUM_W = CW + FW + 1;
    localparam int OFFS  = 1 << (SHIFT - 1);
    localparam int MAXV  = (1 << OW) - 1;

    logic [SUM_W-1:0] raw;
    logic [SUM_W-1:0] adj;

    always_comb begin
        raw = (SUM_W'(coarse) << SHIFT) + SUM_W'(fine);
        adj = raw - SUM_W'(OFFS);
        if (raw < SUM_W'(OFFS)) begin
            word = '0;
        end else if (adj > SUM_W'(MAXV)) begin
            word = OW'(MAXV);
        end else begin
            word = adj[OW-1:0];
        end
    end

endmodule

// File: rtl/sar_be_avg.sv
module sar_be_avg
    import sar_be_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                vld,
    input  logic [SAMPLE_W-1:0] word,
    output logic [AVG_W-1:0]    avg,
    output logic                avg_vld
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

    avg_state_t st_d, st_q;
    logic [AVG_W-1:0] sum;

    always_comb begin
        st_d         = st_q;
        st_d.avg_vld = 1'b0;
        sum          = st_q.acc + AVG_W'(word);
        if (vld) begin
            if (st_q.cnt == '0) begin
                st_d.acc = AVG_W'(word);
            end else begin
                st_d.acc = sum;
            end
            if (st_q.cnt == LAST) begin
                st_d.avg     = sum;
                st_d.avg_vld = 1'b1;
                st_d.cnt     = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign avg     = st_q.avg;
    assign avg_vld = st_q.avg_vld;

endmodule

// File: rtl/sar_be_top.sv
module sar_be_top
    import sar_be_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                word_vld,
    input  logic [COARSE_W-1:0] coarse_code,
    input  logic [FINE_W-1:0]   fine_code,
    output logic [SAMPLE_W-1:0] sample_o,
    output logic                sample_vld_o,
    output logic [AVG_W-1:0]    avg_o,
    output logic                avg_vld_o
);
    logic [SAMPLE_W-1:0] word;
    out_state_t          out_d, out_q;

    sar_be_combine u_combine (
        .coarse (coarse_code),
        .fine   (fine_code),
        .word   (word)
    );

    sar_be_avg u_avg (
        .clk     (clk),
        .rst     (rst),
        .vld     (word_vld),
        .word    (word),
        .avg     (avg_o),
        .avg_vld (avg_vld_o)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vld = word_vld;
        if (word_vld) begin
            out_d.sample = word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign sample_o     = out_q.sample;
    assign sample_vld_o = out_q.vld;

endmodule

// File: rtl/sar_be_chk.sv
module sar_be_chk
    import sar_be_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                word_vld,
    input logic [SAMPLE_W-1:0] sample_o,
    input logic                sample_vld_o,
    input logic [AVG_W-1:0]    avg_o,
    input logic                avg_vld_o
);
    localparam int AVG_MAX = FRAME_LEN * ((1 << SAMPLE_W) - 1);

    a_r4_vld_follows: assert property (@(posedge clk) disable iff (rst)
        word_vld |=> sample_vld_o);

    a_r4_hold_sample: assert property (@(posedge clk) disable iff (rst)
        (!sample_vld_o && !$past(rst)) |-> $stable(sample_o));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        avg_vld_o |=> !avg_vld_o);

    a_r6_with_sample: assert property (@(posedge clk) disable iff (rst)
        avg_vld_o |-> sample_vld_o);

    a_r5_sum_range: assert property (@(posedge clk) disable iff (rst)
        avg_vld_o |-> (int'(avg_o) <= AVG_MAX));

    a_r9_avg_hold: assert property (@(posedge clk) disable iff (rst)
        (!avg_vld_o && !$past(rst)) |-> $stable(avg_o));

    a_r8_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!avg_vld_o && !sample_vld_o && avg_o == '0 && sample_o == '0));

endmodule

bind sar_be_top sar_be_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .word_vld     (word_vld),
    .sample_o     (sample_o),
    .sample_vld_o (sample_vld_o),
    .avg_o        (avg_o),
    .avg_vld_o    (avg_vld_o)
);

// File: tb/tb_sar_be_top.sv
module tb_sar_be_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       word_vld = 1'b0;
    logic [3:0] coarse_code = '0;
    logic [4:0] fine_code = '0;
    logic [7:0] sample_o;
    logic       sample_vld_o;
    logic [9:0] avg_o;
    logic       avg_vld_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int exp_sample = 0;
    int exp_svld   = 0;
    int exp_avg    = 0;
    int exp_avld   = 0;
    int frame_q[$];
    string stag = "R1";

    sar_be_top dut (
        .clk          (clk),
        .rst          (rst),
        .word_vld     (word_vld),
        .coarse_code  (coarse_code),
        .fine_code    (fine_code),
        .sample_o     (sample_o),
        .sample_vld_o (sample_vld_o),
        .avg_o        (avg_o),
        .avg_vld_o    (avg_vld_o)
    );

    always #10 clk = ~clk;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Model one clock edge from the requirements.
    task automatic model(bit r, bit v, int c, int f);
        int raw;
        int w;
        int s;
        if (r) begin
            exp_sample = 0; exp_svld = 0; exp_avg = 0; exp_avld = 0;
            frame_q.delete();
            return;
        end
        exp_svld = v;
        exp_avld = 0;
        if (v) begin
            raw = c * 16 + f;
            if (raw < 8) begin w = 0; stag = "R2"; end
            else if (raw > 263) begin w = 255; stag = "R3"; end
            else begin w = raw - 8; stag = "R1"; end
            exp_sample = w;
            frame_q.push_back(w);
            if (frame_q.size() == 4) begin
                s = 0;
                foreach (frame_q[i]) s += frame_q[i];
                exp_avg  = s;
                exp_avld = 1;
                frame_q.delete();
            end
        end
    endtask

    task automatic step(bit r, bit v, int c, int f);
        rst = r; word_vld = v; coarse_code = 4'(c); fine_code = 5'(f);
        @(posedge clk);
        model(r, v, c, f);
        @(negedge clk);
        if (r) begin
            check("R8 sample", int'(sample_o), 0);
            check("R8 avg", int'(avg_o), 0);
            check("R8 vld", int'(sample_vld_o) + int'(avg_vld_o), 0);
        end else begin
            check(v ? stag : "R4 hold", int'(sample_o), exp_sample);
            check("R4 vld", int'(sample_vld_o), exp_svld);
            check(exp_avld != 0 ? "R5 avg" : "R9 hold", int'(avg_o), exp_avg);
            check("R6 avld", int'(avg_vld_o), exp_avld);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        // R1 mid-range frame, R5 sum, R6 pulse
        step(0, 1, 5, 10);
        step(0, 1, 8, 0);
        step(0, 1, 3, 17);
        step(0, 1, 9, 8);
        // R2 low clamp, stalls between words (R6)
        step(0, 1, 0, 3);
        step(0, 0, 7, 7);
        step(0, 1, 0, 8);
        step(0, 0, 1, 1);
        step(0, 0, 1, 1);
        step(0, 1, 0, 0);
        step(0, 1, 0, 7);
        // R3 high clamp closing the frame, same cycle as sample (R7 fresh frame)
        step(0, 1, 15, 23);
        step(0, 1, 15, 24);
        step(0, 1, 15, 31);
        step(0, 1, 15, 31);
        step(0, 0, 2, 2);
        // R8 reset in the cycle a frame would close
        step(0, 1, 4, 4);
        step(0, 1, 4, 4);
        step(0, 1, 4, 4);
        step(1, 1, 4, 4);
        step(0, 1, 6, 0);
        step(0, 1, 6, 0);
        step(0, 1, 6, 0);
        step(0, 1, 6, 31);
        // Random code pairs including fine extremes 0 and 31
        for (int i = 0; i < 400; i++) begin
            int f;
            f = $urandom_range(0, 31);
            if (i % 7 == 0) f = 0;
            if (i % 11 == 0) f = 31;
            step(0, ($urandom_range(0, 3) != 0), $urandom_range(0, 15), f);
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule